// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block times a single transfer on an external memory or peripheral bus. An internal requester hands over an address, write data, a direction bit and a chip-select window index through a valid/ready handshake. The block then steps through five phases in a fixed order: address setup, command delay, write-data setup (or bus turnaround), access, and hold. It drives the address, an address latch enable, read and write strobes, the data output enable and a one-hot chip select while it does so.

Each chip-select window owns a timing register that sets the length of every phase. The timing is copied when a request is accepted, so a register write made during a transfer does not disturb it. The access phase can be stretched by an external READY input when the window enables this. Address setup is lengthened only when the window differs from the one used by the previous transfer. A one-cycle done pulse presents the captured read data, and the next request may be taken in that same cycle.

Top module: `extbus_seq`

## Requirements
- R1: A transfer accepted on a clock edge keeps a chip select active for exactly N cycles, where N = (address setup) + (command delay) + (data setup) + (access, including waits) + (hold). `done` is high in the cycle after those N cycles.
- R2: Address setup lasts 1 cycle when timing bit [0] is 0 and 2 cycles when it is 1. It gains the count in bits [2:1] (0..3) only when the window index differs from that of the previous accepted transfer. The first transfer after reset always gains it.
- R3: Command delay lasts bits [4:3] cycles (0..3), data setup lasts bit [5] cycles (0..1) and hold lasts bits [12:11] cycles (0..3). A phase of length zero takes no cycle.
- R4: The access phase lasts (bits [10:6]) + 1 cycles, from 1 to 32.
- R5: When timing bit [13] is 1, the access phase ends on the first rising edge at which its minimum length has elapsed and `bus_ready` is high. When bit [13] is 0, `bus_ready` has no effect on any cycle count.
- R6: `bus_ale` is high in exactly the address setup cycles. `bus_addr` holds the request address, unchanged while a chip select is active.
- R7: During the access phase, `bus_rd` is high for reads and `bus_wr` is high for writes. Both are low at every other time and never high together.
- R8: For writes, `bus_doe` is high from the start of data setup through the end of hold, with `bus_dout` equal to the write data. For reads, `bus_doe` is never high.
- R9: `bus_cs` is one-hot, with bit `req_win` set for the whole transfer. It is all zero when no transfer is active, including the done cycle.
- R10: `done` is a single-cycle pulse. For reads, `rdata` equals `bus_din` as sampled on the last access-phase edge. `req_ready` is high in idle and in the done cycle.
- R11: A window's timing is written with `cfg_we`/`cfg_win`/`cfg_wdata` and takes effect at the next accepted request. A write during a transfer does not alter that transfer.
- R12: After reset, `req_ready` is high, `done` is low and every strobe, enable and chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_win | input | WIN_W | Window whose timing is written |
| cfg_wdata | input | 14 | Timing word (fields as in R2 to R5) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | WIN_W | Chip-select window index |
| bus_addr | output | ADDR_W | External address |
| bus_ale | output | 1 | Address latch enable |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_doe | output | 1 | Data output enable |
| bus_dout | output | DATA_W | Data driven to the bus |
| bus_din | input | DATA_W | Data read from the bus |
| bus_ready | input | 1 | External access-phase ready |
| bus_cs | output | NWIN | One-hot chip selects |
| done | output | 1 | Transfer complete pulse |
| rdata | output | DATA_W | Captured read data |

## Verification
A request accepted on edge k puts the address setup phase on the outputs from the next cycle. Every phase, strobe and enable therefore shows up one register after its cause, and `done` appears N cycles after edge k. The bench samples on falling edges and counts, per transfer, the cycles with chip select, latch enable, strobe and output enable. It compares each count with the sum it derives from the timing word. READY is driven on a falling edge from the number of strobe cycles already seen, so the edge at which the access phase may end is known in advance. Read data is checked in the done cycle against the value presented during the strobe.

// File: rtl/extbus_pkg.sv
package extbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_AB, PH_C, PH_D, PH_E, PH_F, PH_DONE
    } phase_e;

    // Timing word, MSB first
    typedef struct packed {
        logic       rdy_en;   // [13]
        logic [1:0] hold;     // [12:11]
        logic [4:0] acc;      // [10:6] access length - 1
        logic       dset;     // [5]
        logic [1:0] cmd;      // [4:3]
        logic [1:0] ab_ext;   // [2:1]
        logic       ab_long;  // [0]
    } tcfg_t;

    localparam int CFG_W = $bits(tcfg_t);

    // Length of a phase entered after address setup
    function automatic logic [5:0] ph_len(phase_e p, tcfg_t c);
        case (p)
            PH_C:    ph_len = {4'd0, c.cmd};
            PH_D:    ph_len = {5'd0, c.dset};
            PH_E:    ph_len = {1'b0, c.acc} + 6'd1;
            PH_F:    ph_len = {4'd0, c.hold};
            default: ph_len = 6'd0;
        endcase
    endfunction

    // Next phase with nonzero length
    function automatic phase_e ph_next(phase_e p, tcfg_t c);
        case (p)
            PH_AB:   ph_next = (c.cmd != 2'd0) ? PH_C : (c.dset ? PH_D : PH_E);
            PH_C:    ph_next = c.dset ? PH_D : PH_E;
            PH_D:    ph_next = PH_E;
            PH_E:    ph_next = (c.hold != 2'd0) ? PH_F : PH_DONE;
            default: ph_next = PH_DONE;
        endcase
    endfunction

endpackage

// File: rtl/ebs_cfg_bank.sv
module ebs_cfg_bank
    import extbus_pkg::*;
#(
    parameter int NWIN  = 4,
    localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIN_W-1:0] wr_win,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [WIN_W-1:0] rd_win,
    output tcfg_t            rd_cfg
);
    tcfg_t regs [NWIN];

    for (genvar i = 0; i < NWIN; i++) begin : g_win
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (wr_en && wr_win == WIN_W'(i))
                regs[i] <= tcfg_t'(wr_data);
        end
    end

    assign rd_cfg = regs[rd_win];
endmodule

// File: rtl/ebs_phase_seq.sv
module ebs_phase_seq
    import extbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int WIN_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic [WIN_W-1:0]  req_win,
    input  tcfg_t             cfg_sel,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ready,
    output phase_e            phase,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic              cur_write,
    output logic [WIN_W-1:0]  cur_win,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    phase_e           phase_q;
    logic [5:0]       cnt_q;
    tcfg_t            cfg_q;
    logic [WIN_W-1:0] prev_win_q;
    logic             prev_vld_q;

    logic       accept, win_chg, last, waiting;
    logic [5:0] ab_len, nxt_len;
    phase_e     nxt;

    assign req_ready = (phase_q == PH_IDLE) || (phase_q == PH_DONE);
    assign accept    = req_valid && req_ready;
    assign win_chg   = !prev_vld_q || (prev_win_q != req_win);
    assign ab_len    = 6'd1 + {5'd0, cfg_sel.ab_long}
                     + (win_chg ? {4'd0, cfg_sel.ab_ext} : 6'd0);
    assign waiting   = (phase_q == PH_E) && cfg_q.rdy_en && !bus_ready;
    assign last      = (cnt_q == 6'd0) && !waiting;
    assign nxt       = ph_next(phase_q, cfg_q);
    assign nxt_len   = ph_len(nxt, cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_IDLE;
            cnt_q      <= '0;
            cfg_q      <= '0;
            prev_win_q <= '0;
            prev_vld_q <= 1'b0;
            cur_addr   <= '0;
            cur_wdata  <= '0;
            cur_write  <= 1'b0;
            cur_win    <= '0;
            rdata      <= '0;
        end else if (accept) begin
            phase_q    <= PH_AB;
            cnt_q      <= ab_len - 6'd1;
            cfg_q      <= cfg_sel;
            prev_win_q <= req_win;
            prev_vld_q <= 1'b1;
            cur_addr   <= req_addr;
            cur_wdata  <= req_wdata;
            cur_write  <= req_write;
            cur_win    <= req_win;
        end else if (phase_q == PH_DONE) begin
            phase_q <= PH_IDLE;
        end else if (phase_q != PH_IDLE) begin
            if (last) begin
                phase_q <= nxt;
                cnt_q   <= (nxt_len == 6'd0) ? 6'd0 : nxt_len - 6'd1;
                if (phase_q == PH_E && !cur_write)
                    rdata <= bus_din;
            end else if (cnt_q != 6'd0) begin
                cnt_q <= cnt_q - 6'd1;
            end
        end
    end

    assign phase = phase_q;
    assign done  = (phase_q == PH_DONE);

    AST_READY_WAIT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_E && cnt_q == 6'd0 && cfg_q.rdy_en && !bus_ready) |=> (phase_q == PH_E)) // R5
        else $error("access ended while READY low");
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) // R10
        else $error("done longer than one cycle");
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (phase_q inside {PH_AB, PH_C, PH_D, PH_E, PH_F}) |-> !req_ready) // R10
        else $error("ready while busy");
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
    import extbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int NWIN   = 4,
    localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [WIN_W-1:0]  cfg_win,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic [WIN_W-1:0]  req_win,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_ale,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_doe,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ready,
    output logic [NWIN-1:0]   bus_cs,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    tcfg_t            cfg_sel;
    phase_e           phase;
    logic             cur_write, active;
    logic [WIN_W-1:0] cur_win;

    ebs_cfg_bank #(.NWIN(NWIN)) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_win(cfg_win), .wr_data(cfg_wdata),
        .rd_win(req_win), .rd_cfg(cfg_sel)
    );

    ebs_phase_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_write(req_write), .req_win(req_win),
        .cfg_sel(cfg_sel), .bus_din(bus_din), .bus_ready(bus_ready),
        .phase(phase), .cur_addr(bus_addr), .cur_wdata(bus_dout),
        .cur_write(cur_write), .cur_win(cur_win),
        .done(done), .rdata(rdata)
    );

    assign active  = phase inside {PH_AB, PH_C, PH_D, PH_E, PH_F};
    assign bus_ale = (phase == PH_AB);
    assign bus_rd  = (phase == PH_E) && !cur_write;
    assign bus_wr  = (phase == PH_E) && cur_write;
    assign bus_doe = cur_write && (phase inside {PH_D, PH_E, PH_F});

    for (genvar i = 0; i < NWIN; i++) begin : g_cs
        assign bus_cs[i] = active && (cur_win == WIN_W'(i));
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr)) // R7
        else $error("both strobes");
    AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> (!bus_rd && !bus_wr && !bus_doe)) // R6
        else $error("ALE overlaps command");
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bus_cs)) // R9
        else $error("chip select not one-hot");
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (bus_cs != '0) |=> (bus_cs == '0 || $stable(bus_addr))) // R6
        else $error("address moved in transfer");
    AST_READ_NO_DOE: assert property (@(posedge clk) disable iff (rst)
        bus_rd |-> !bus_doe) // R8
        else $error("data driven on read");
endmodule

// File: tb/sim_extbus_seq.sv
module sim_extbus_seq;
    localparam int ADDR_W = 24, DATA_W = 16, NWIN = 4, WIN_W = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 0; logic [WIN_W-1:0] cfg_win = 0; logic [13:0] cfg_wdata = 0;
    logic req_valid = 0, req_ready, req_write = 0;
    logic [ADDR_W-1:0] req_addr = 0, bus_addr;
    logic [DATA_W-1:0] req_wdata = 0, bus_dout, bus_din = 0, rdata;
    logic [WIN_W-1:0] req_win = 0;
    logic bus_ale, bus_rd, bus_wr, bus_doe, bus_ready = 0, done;
    logic [NWIN-1:0] bus_cs;

    int checks = 0, errors = 0, cycles = 0, prev_win = -1;

    always #2 clk = ~clk;

    extbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NWIN(NWIN)) u0 (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int w, input logic [13:0] d);
        cfg_we = 1; cfg_win = WIN_W'(w); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // Caller is at a falling edge.
    task automatic xfer(input int w, input logic wr, input logic [13:0] t,
                        input int waits, input logic mid, input logic [13:0] alt);
        int lab, lc, ld, le, lf, n;
        int ncs, ncsok, nale, nstr, ndoe, guard;
        logic seen;
        logic [DATA_W-1:0] din;
        logic [ADDR_W-1:0] a;
        a   = ADDR_W'(32'h5A0000 + cycles * 7);
        din = DATA_W'(16'h3C00 ^ cycles);
        lab = 1 + int'(t[0]) + ((w != prev_win) ? int'(t[2:1]) : 0);
        lc = int'(t[4:3]); ld = int'(t[5]); lf = int'(t[12:11]);
        le = int'(t[10:6]) + 1;
        if (t[13] && waits + 1 > le) le = waits + 1;
        n = lab + lc + ld + le + lf;
        prev_win = w;
        req_valid = 1; req_win = WIN_W'(w); req_write = wr;
        req_addr = a; req_wdata = ~din;
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1 req_valid = 0;
        ncs = 0; ncsok = 0; nale = 0; nstr = 0; ndoe = 0; guard = 0; seen = 0;
        while (!seen && guard < 200) begin
            @(negedge clk);
            guard++;
            if (mid && guard == 1) begin
                cfg_we = 1; cfg_win = WIN_W'(w); cfg_wdata = alt;
            end else cfg_we = 0;
            if (done) begin
                seen = 1;
                chk("R1 R3 total length", ncs, n);
                chk("R9 cs select", ncsok, n);
                chk("R9 cs clear in done", bus_cs, 0);
                chk("R2 R6 ale cycles", nale, lab);
                chk("R4 R5 R7 strobe cycles", nstr, le);
                chk("R8 doe cycles", ndoe, wr ? (ld + le + lf) : 0);
                chk("R10 ready in done", req_ready, 1);
                if (!wr) chk("R10 read data", rdata, din);
            end else begin
                if (bus_cs != 0) ncs++;
                if (bus_cs == (NWIN'(1) << w)) ncsok++;
                if (bus_cs != 0 && bus_addr != a) chk("R6 address", bus_addr, a);
                if (bus_ale) nale++;
                if (bus_rd || bus_wr) begin
                    nstr++;
                    if (bus_rd == wr) chk("R7 strobe kind", bus_wr, wr);
                end
                if (bus_doe) begin
                    ndoe++;
                    if (bus_dout != ~din) chk("R8 write data", bus_dout, ~din);
                end
            end
            bus_ready = (bus_rd || bus_wr) && (nstr > waits);
            bus_din   = bus_rd ? din : ~din;
        end
        cfg_we = 0;
        if (!seen) chk("R1 done seen", 0, 1);
    endtask

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk("R12 ready", req_ready, 1);
        chk("R12 done", done, 0);
        chk("R12 cs", bus_cs, 0);
        chk("R12 strobes", {bus_ale, bus_rd, bus_wr, bus_doe}, 0);

        // R2: first transfer after reset takes the extension
        write_cfg(1, 14'b0_00_00000_0_00_11_0);
        xfer(1, 0, 14'b0_00_00000_0_00_11_0, 0, 0, 0);
        xfer(1, 0, 14'b0_00_00000_0_00_11_0, 0, 0, 0); // same window: no extension

        // Near-exhaustive sweep
        k = 0;
        for (int ab = 0; ab < 2; ab++)
            for (int c = 0; c < 4; c++)
                for (int d = 0; d < 2; d++)
                    for (int f = 0; f < 4; f++)
                        for (int e = 0; e < 3; e++) begin
                            logic [13:0] t;
                            int w;
                            t[0] = 1'(ab); t[2:1] = 2'((c + f) % 4);
                            t[4:3] = 2'(c); t[5] = 1'(d);
                            t[10:6] = (e == 0) ? 5'd0 : (e == 1) ? 5'd2 : 5'd31;
                            t[12:11] = 2'(f); t[13] = (k % 3 == 0);
                            w = (k / 2) % NWIN;
                            write_cfg(w, t);
                            xfer(w, 1'(k % 2), t, k % 5, 0, 0);
                            k++;
                        end

        // R5: READY ignored when disabled, long waits when enabled
        write_cfg(2, 14'b0_01_00001_1_01_00_0);
        xfer(2, 0, 14'b0_01_00001_1_01_00_0, 9, 0, 0);
        write_cfg(2, 14'b1_01_00001_1_01_00_0);
        xfer(2, 1, 14'b1_01_00001_1_01_00_0, 9, 0, 0);
        // back-to-back from the done cycle
        xfer(2, 0, 14'b1_01_00001_1_01_00_0, 0, 0, 0);

        // R11: write during a transfer does not change it
        write_cfg(3, 14'b0_00_00011_0_10_00_1);
        xfer(3, 0, 14'b0_00_00011_0_10_00_1, 0, 1, 14'b0_11_01111_1_11_11_1);
        xfer(3, 1, 14'b0_11_01111_1_11_11_1, 0, 0, 0);

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule